// File: doc/BRIEF.md
# Chip-Select Output Port with Set/Clear Strobes

This block drives a small bank of general-purpose output pins, any of which can serve as an active-low style chip select for a serial peripheral bus master. Software reaches it through two write-only registers on a simple write port. The first is a configuration register. Its high half marks each pin as a chip select, and its low half inverts the level that pin drives. The second is a strobe register whose high half sets pin values and whose low half clears them. This lets one write change any subset of pins without reading the current state back.

Chip selects are numbered from one, so select number k is pin k-1. A cleared pin means its select is asserted and a set pin means it is released. For that reason, reset leaves every stored value set. The pad level is the stored value exclusive-ORed with the pin's invert bit. Setup and hold spacing around a select edge belongs to the software or master that issues the strobes.

The write decoder is a single `unique case` over an enumerated register selector with three outcomes:
- CFG loads the configuration register.
- STROBE applies set/clear masks.
- Any other selector (DEFAULT) does nothing.

Each pin is one generated cell with a single stored bit. That bit goes HOLD → SET on a set mask bit, and HOLD → CLEAR on a clear mask bit with no set bit beside it.

Top module: `selport`

## Requirements
- R1: After reset every stored value is 1, the invert bits and chip-select-mode bits are 0, so `pad_o` reads all ones and `sel_o` reads all zeros.
- R2: A write to the strobe register (address 1) with data bit NPINS+n equal to 1 sets stored value n; the change is visible at the outputs after the next rising clock edge.
- R3: A strobe write with data bit n equal to 1 and bit NPINS+n equal to 0 clears stored value n.
- R4: Strobe bits written as 0 leave the matching stored values unchanged.
- R5: When bits NPINS+n and n are both 1 in one strobe write, pin n ends set.
- R6: `pad_o[n]` equals stored value n XOR configuration bit n (the invert field, low half of the configuration register at address 0).
- R7: Configuration bit NPINS+n selects chip-select mode for pin n. `sel_o[n]` is 1 exactly when pin n is in that mode and its stored value is 0. A pin not in that mode still drives its stored value on `pad_o`.
- R8: Chip select number k, counted from 1, is controlled by strobe bits k-1 (clear, asserts) and NPINS+k-1 (set, releases) and reported on `sel_o[k-1]`.
- R9: A write with `wr_en` low, or to an address other than 0 or 1, changes no output.
- R10: A configuration write leaves every stored value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one access per cycle it is high |
| wr_addr | input | 2 | Register select: 0 configuration, 1 set/clear strobe |
| wr_data | input | 2*NPINS | Write data |
| pad_o | output | NPINS | Pin levels after inversion |
| sel_o | output | NPINS | Asserted chip selects (pins in select mode whose stored value is 0) |

## Verification
The assertions assume `wr_en`, `wr_addr` and `wr_data` are driven to known values at each rising edge while reset is released, and that a write lasts exactly one cycle. The set-wins and hold properties reason only about cycles whose masks come from such a clean access. The bench changes every input at the falling edge and drops `wr_en` after one cycle, so no edge sees a half-updated access. It still exercises simultaneous set and clear, unmapped addresses and disabled writes.

// File: rtl/selport_pkg.sv
package selport_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CFG    = 2'd0,
        REG_STROBE = 2'd1
    } reg_sel_e;
endpackage

// File: rtl/selport_decode.sv
module selport_decode
    import selport_pkg::*;
#(
    parameter int NPINS = 8,
    localparam int DW = 2 * NPINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              cfg_we,
    output logic [NPINS-1:0]  set_mask,
    output logic [NPINS-1:0]  clr_mask
);
    always_comb begin
        cfg_we   = 1'b0;
        set_mask = '0;
        clr_mask = '0;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_addr))
                REG_CFG:    cfg_we = 1'b1;
                REG_STROBE: begin
                    set_mask = wr_data[DW-1:NPINS];
                    clr_mask = wr_data[NPINS-1:0];
                end
                default:    ;
            endcase
        end
    end

    // R9: no access means no effect reaches the register file
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (!cfg_we && set_mask == '0 && clr_mask == '0));

    a_r9_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > ADDR_W'(1)) |-> (!cfg_we && set_mask == '0 && clr_mask == '0));
endmodule

// File: rtl/selport_cell.sv
module selport_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic inv_i,
    input  logic mode_i,
    output logic pad_o,
    output logic sel_o
);
    logic q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b1;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    always_comb begin
        pad_o = q ^ inv_i;
        sel_o = mode_i & ~q;
    end

    // R2 and R5: a set request wins, alone or alongside a clear
    a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> (pad_o ^ inv_i));

    // R3
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !(pad_o ^ inv_i));

    // R4
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q));
endmodule

// File: rtl/selport.sv
module selport
    import selport_pkg::*;
#(
    parameter int NPINS = 8,
    localparam int DW = 2 * NPINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [NPINS-1:0]  pad_o,
    output logic [NPINS-1:0]  sel_o
);
    logic             cfg_we;
    logic [NPINS-1:0] set_mask;
    logic [NPINS-1:0] clr_mask;
    logic [NPINS-1:0] cfg_mode;
    logic [NPINS-1:0] cfg_inv;

    selport_decode #(.NPINS(NPINS)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg_we   (cfg_we),
        .set_mask (set_mask),
        .clr_mask (clr_mask)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_mode <= '0;
            cfg_inv  <= '0;
        end else if (cfg_we) begin
            cfg_mode <= wr_data[DW-1:NPINS];
            cfg_inv  <= wr_data[NPINS-1:0];
        end
    end

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        selport_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_mask[n]),
            .clr_i  (clr_mask[n]),
            .inv_i  (cfg_inv[n]),
            .mode_i (cfg_mode[n]),
            .pad_o  (pad_o[n]),
            .sel_o  (sel_o[n])
        );
    end

    // R10: a configuration write moves pads only by the change of invert bits
    a_r10_cfg_keeps_values: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ((pad_o ^ cfg_inv) == $past(pad_o ^ cfg_inv)));

    // R7: a select is only reported for a pin in select mode
    a_r7_sel_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_o & ~cfg_mode) == '0));
endmodule

// File: tb/test_selport.sv
module test_selport;
    localparam int NPINS = 8;
    localparam int NV = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  pad_o;
    logic [7:0]  sel_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    selport #(.NPINS(NPINS)) i_selport (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pad_o(pad_o), .sel_o(sel_o)
    );

    // {req(4), en(1), addr(2), data(16), pad(8), sel(8)}
    localparam logic [38:0] VEC [NV] = '{
        {4'd3,  1'b1, 2'd1, 16'h0001, 8'hFE, 8'h00}, // R3 clear pin 0
        {4'd2,  1'b1, 2'd1, 16'h0100, 8'hFF, 8'h00}, // R2 set pin 0
        {4'd3,  1'b1, 2'd1, 16'h00F0, 8'h0F, 8'h00}, // R3 clear upper nibble
        {4'd4,  1'b1, 2'd1, 16'h0000, 8'h0F, 8'h00}, // R4 zero bits hold
        {4'd5,  1'b1, 2'd1, 16'h1010, 8'h1F, 8'h00}, // R5 set beats clear on pin 4
        {4'd6,  1'b1, 2'd0, 16'h000F, 8'h10, 8'h00}, // R6 R10 invert low nibble
        {4'd7,  1'b1, 2'd0, 16'hFF00, 8'h1F, 8'hE0}, // R7 all pins in select mode
        {4'd9,  1'b1, 2'd2, 16'h00FF, 8'h1F, 8'hE0}, // R9 unmapped address
        {4'd9,  1'b0, 2'd1, 16'h00FF, 8'h1F, 8'hE0}, // R9 write disabled
        {4'd2,  1'b1, 2'd1, 16'hE000, 8'hFF, 8'h00}, // R2 set pins 5..7
        {4'd6,  1'b1, 2'd0, 16'h03AA, 8'h55, 8'h00}, // R6 R7 mixed modes
        {4'd7,  1'b1, 2'd1, 16'h0003, 8'h56, 8'h03}, // R7 select ignores invert
        {4'd2,  1'b1, 2'd1, 16'hFF00, 8'h55, 8'h00}  // R2 release all
    };

    task automatic check(input string req, input logic [7:0] pad_exp,
                         input logic [7:0] sel_exp);
        checks++;
        if (pad_o !== pad_exp || sel_o !== sel_exp) begin
            errors++;
            $display("FAIL %s pad=%h sel=%h expected pad=%h sel=%h",
                     req, pad_o, sel_o, pad_exp, sel_exp);
        end
    endtask

    task automatic access(input logic en, input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R1", 8'hFF, 8'h00);            // reset state
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 8'hFF, 8'h00);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][34], VEC[i][33:32], VEC[i][31:16]);
            check($sformatf("R%0d", VEC[i][38:35]), VEC[i][15:8], VEC[i][7:0]);
        end

        // R8: select number k lives at index k-1
        access(1'b1, 2'd0, 16'hFF00);
        for (int k = 1; k <= NPINS; k++) begin
            access(1'b1, 2'd1, 16'h0001 << (k - 1));
            check("R8", ~(8'h01 << (k - 1)), 8'h01 << (k - 1));
            access(1'b1, 2'd1, 16'h0100 << (k - 1));
            check("R8", 8'hFF, 8'h00);
        end

        // R10: configuration write keeps the asserted selects
        access(1'b1, 2'd1, 16'h0081);
        access(1'b1, 2'd0, 16'h81FF);
        check("R10", 8'h81, 8'h81);

        // R1: reset in the middle of activity
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 8'hFF, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 8'hFF, 8'h00);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule